// File: doc/BRIEF.md
# Processor Status Register Unit

This block keeps a processor's status state: six condition flags, three system control flags and a five-bit interrupt level mask. It also holds two banked stack pointers, one for system mode and one for user mode, next to the live stack pointer that the register file uses. Software reaches all of this through a register access port. Each access names a select code. A write takes effect on the next rising clock edge. A read returns the current contents in the same cycle.

Two side effects set the block apart from plain storage. First, a write to the interrupt level mask cannot bring a mask of 16 or more down below 16. Second, any write that flips the stack-select flag swaps the live stack pointer with the right banked copy. The flag can be flipped through the condition byte or through the full status word. The register file reads the live stack pointer continuously and may overwrite it through its own port.

The access port is a control path, so it has no valid/ready handshake. It accepts one access in every cycle that `acc_en` is high and never applies back-pressure. The register-file port is the same: it accepts a write in any cycle.

Top module: `psr_unit`

## Requirements
- R1: After reset every field, the live stack pointer, both banked stack pointers and the four plain registers read as zero.
- R2: Select 1 (condition byte) keeps write bits 5:0 and reads them back zero-extended. The bits are carry at bit 0, overflow at bit 1, zero at bit 2, negative at bit 3, interrupt enable at bit 4 and stack select at bit 5.
- R3: Select 2 (control field) keeps write bits 2:0 and reads them back zero-extended. The bits are trace at bit 0 and debug flags at bits 1 and 2.
- R4: Select 3 (level mask) stores the written bits 4:0. The one exception: if the current mask is 16 or more and the written value is below 16, the block stores the written value plus 16.
- R5: Select 0 (status word) reads the condition byte at bits 7:0, the control field at bits 10:8 and the level mask at bits 20:16, with all other bits zero. A write to select 0 updates all three fields in one cycle, and the level-mask rule of R4 applies.
- R6: A write that changes stack select swaps the stack pointers, judged against the flag value before the write. On a change from 1 to 0, the live SP goes to the user bank and the system bank goes to the live SP. On a change from 0 to 1, the live SP goes to the system bank and the user bank goes to the live SP. A write that leaves the flag unchanged moves nothing.
- R7: Select 4 (system SP) reads and writes the live SP when stack select is 0, and the system bank otherwise. Select 5 (user SP) reads and writes the live SP when stack select is 1, and the user bank otherwise.
- R8: Selects 6 to 9 (table base, return pointer, multiply high, multiply low) are plain 32-bit registers with no side effects.
- R9: A register-file write loads the live SP on the next edge. It is dropped in a cycle where an access write also changes the live SP, either through a swap or through the routing of R7.
- R10: Selects 10 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access present this cycle |
| acc_we | input | 1 | Access is a write |
| acc_sel | input | 4 | Register select code |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for acc_sel, combinational |
| sp_live | output | 32 | Live stack pointer to the register file |
| sp_rf_we | input | 1 | Register-file write of the live SP |
| sp_rf_wdata | input | 32 | Register-file write data |

## Verification
The bench flips stack select in both directions, once through the condition byte and once through the status word. It then reads both stack-pointer selects. A design that compares against the new flag or misroutes the banks would show a swapped or stale pointer. The level-mask sequence raises the mask past 16 and then writes smaller values through both selects. A missing floor would show up as a mask that drops below 16. The bench also writes through the register-file port in the same cycle as an access that changes the live SP. A design with the wrong priority would keep the register-file value. Finally, writes to reserved selects and writes that leave stack select unchanged are checked at the ports for side effects.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int DW     = 32;
  localparam int SEL_W  = 4;
  localparam int COND_W = 6;
  localparam int CTRL_W = 3;
  localparam int LVL_W  = 5;
  localparam int N_PLAIN = 4;
  localparam int S_BIT  = 5;

  typedef enum logic [SEL_W-1:0] {
    SEL_STATUS = 4'd0,
    SEL_COND   = 4'd1,
    SEL_CTRL   = 4'd2,
    SEL_LEVEL  = 4'd3,
    SEL_SYS_SP = 4'd4,
    SEL_USR_SP = 4'd5,
    SEL_PLAIN0 = 4'd6
  } psr_sel_e;
endpackage

// File: rtl/psr_flags.sv
module psr_flags #(
  parameter int COND_W = 6,
  parameter int CTRL_W = 3,
  parameter int LVL_W  = 5,
  parameter int S_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cond_we,
  input  logic [COND_W-1:0] cond_wd,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wd,
  input  logic              lvl_we,
  input  logic [LVL_W-1:0]  lvl_wd,
  output logic [COND_W-1:0] cond_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [LVL_W-1:0]  lvl_q,
  output logic              swap_o
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(1) << (LVL_W-1);

  logic [LVL_W-1:0] lvl_next;

  // A high mask keeps its top bit: low values are lifted into the upper half.
  always_comb begin
    lvl_next = lvl_wd;
    if (lvl_q[LVL_W-1] && !lvl_wd[LVL_W-1]) lvl_next = lvl_wd | HALF;
  end

  assign swap_o = cond_we && (cond_wd[S_BIT] != cond_q[S_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q <= '0;
      ctrl_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (cond_we) cond_q <= cond_wd;
      if (ctrl_we) ctrl_q <= ctrl_wd;
      if (lvl_we)  lvl_q  <= lvl_next;
    end
  end

  p_level_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_we && lvl_q[LVL_W-1]) |=> lvl_q[LVL_W-1]);
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_q == $past(ctrl_wd));
  p_cond_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_we |=> $stable(cond_q));
endmodule

// File: rtl/psr_stack_bank.sv
module psr_stack_bank #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_cur,
  input  logic          swap,
  input  logic          sys_we,
  input  logic          usr_we,
  input  logic [DW-1:0] wd,
  input  logic          rf_we,
  input  logic [DW-1:0] rf_wd,
  output logic [DW-1:0] live_q,
  output logic [DW-1:0] sys_rd,
  output logic [DW-1:0] usr_rd
);
  logic [DW-1:0] ssp_q, usp_q;
  logic [DW-1:0] live_n, ssp_n, usp_n;

  always_comb begin
    live_n = live_q;
    ssp_n  = ssp_q;
    usp_n  = usp_q;
    if (swap) begin
      if (s_cur) begin
        usp_n  = live_q;
        live_n = ssp_q;
      end else begin
        ssp_n  = live_q;
        live_n = usp_q;
      end
    end else if (sys_we && !s_cur) live_n = wd;
    else if (usr_we && s_cur)      live_n = wd;
    else begin
      if (sys_we) ssp_n = wd;
      if (usr_we) usp_n = wd;
      if (rf_we)  live_n = rf_wd;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= '0;
      ssp_q  <= '0;
      usp_q  <= '0;
    end else begin
      live_q <= live_n;
      ssp_q  <= ssp_n;
      usp_q  <= usp_n;
    end
  end

  assign sys_rd = s_cur ? ssp_q : live_q;
  assign usr_rd = s_cur ? live_q : usp_q;

  p_swap_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && s_cur) |=> (live_q == $past(ssp_q)) && (usp_q == $past(live_q)));
  p_swap_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (swap && !s_cur) |=> (live_q == $past(usp_q)) && (ssp_q == $past(live_q)));
  p_rf_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && !swap && !sys_we && !usr_we) |=> live_q == $past(rf_wd));
endmodule

// File: rtl/psr_plain_regs.sv
module psr_plain_regs #(
  parameter int DW = 32,
  parameter int N  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    we,
  input  logic [DW-1:0]   wd,
  output logic [N*DW-1:0] rd
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (we[i]) q <= wd;
    end
    assign rd[i*DW +: DW] = q;

    p_plain_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we[i] |=> q == $past(wd));
  end
endmodule

// File: rtl/psr_unit.sv
module psr_unit
  import psr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_we,
  input  logic [SEL_W-1:0] acc_sel,
  input  logic [DW-1:0]    acc_wdata,
  output logic [DW-1:0]    acc_rdata,
  output logic [DW-1:0]    sp_live,
  input  logic             sp_rf_we,
  input  logic [DW-1:0]    sp_rf_wdata
);
  localparam int CTRL_LSB = 8;
  localparam int LVL_LSB  = 16;

  logic wr, w_status;
  logic [COND_W-1:0] cond_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LVL_W-1:0]  lvl_q;
  logic swap;
  logic [DW-1:0] sys_rd, usr_rd;
  logic [N_PLAIN-1:0] plain_we;
  logic [N_PLAIN*DW-1:0] plain_rd;

  assign wr       = acc_en && acc_we;
  assign w_status = wr && (acc_sel == SEL_STATUS);

  psr_flags #(.COND_W(COND_W), .CTRL_W(CTRL_W), .LVL_W(LVL_W), .S_BIT(S_BIT)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .cond_we(w_status || (wr && acc_sel == SEL_COND)),
    .cond_wd(acc_wdata[COND_W-1:0]),
    .ctrl_we(w_status || (wr && acc_sel == SEL_CTRL)),
    .ctrl_wd(w_status ? acc_wdata[CTRL_LSB +: CTRL_W] : acc_wdata[CTRL_W-1:0]),
    .lvl_we(w_status || (wr && acc_sel == SEL_LEVEL)),
    .lvl_wd(w_status ? acc_wdata[LVL_LSB +: LVL_W] : acc_wdata[LVL_W-1:0]),
    .cond_q(cond_q), .ctrl_q(ctrl_q), .lvl_q(lvl_q), .swap_o(swap)
  );

  psr_stack_bank #(.DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .s_cur(cond_q[S_BIT]), .swap(swap),
    .sys_we(wr && acc_sel == SEL_SYS_SP), .usr_we(wr && acc_sel == SEL_USR_SP),
    .wd(acc_wdata), .rf_we(sp_rf_we), .rf_wd(sp_rf_wdata),
    .live_q(sp_live), .sys_rd(sys_rd), .usr_rd(usr_rd)
  );

  for (genvar i = 0; i < N_PLAIN; i++) begin : g_pwe
    assign plain_we[i] = wr && (acc_sel == SEL_W'(int'(SEL_PLAIN0) + i));
  end

  psr_plain_regs #(.DW(DW), .N(N_PLAIN)) u_plain (
    .clk(clk), .rst_n(rst_n), .we(plain_we), .wd(acc_wdata), .rd(plain_rd)
  );

  always_comb begin
    acc_rdata = '0;
    case (acc_sel)
      SEL_STATUS: begin
        acc_rdata[COND_W-1:0]          = cond_q;
        acc_rdata[CTRL_LSB +: CTRL_W]  = ctrl_q;
        acc_rdata[LVL_LSB +: LVL_W]    = lvl_q;
      end
      SEL_COND:   acc_rdata[COND_W-1:0] = cond_q;
      SEL_CTRL:   acc_rdata[CTRL_W-1:0] = ctrl_q;
      SEL_LEVEL:  acc_rdata[LVL_W-1:0]  = lvl_q;
      SEL_SYS_SP: acc_rdata = sys_rd;
      SEL_USR_SP: acc_rdata = usr_rd;
      default: begin
        for (int i = 0; i < N_PLAIN; i++)
          if (acc_sel == SEL_W'(int'(SEL_PLAIN0) + i)) acc_rdata = plain_rd[i*DW +: DW];
      end
    endcase
  end

  p_status_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_sel == SEL_STATUS) |-> (acc_rdata[DW-1:LVL_LSB+LVL_W] == '0));
  p_reserved_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_sel >= SEL_W'(int'(SEL_PLAIN0) + N_PLAIN) && !sp_rf_we) |=> $stable(sp_live));
endmodule

// File: tb/tb_psr_unit.sv
module tb_psr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_en = 1'b0, acc_we = 1'b0;
  logic [3:0]  acc_sel = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata, sp_live;
  logic        sp_rf_we = 1'b0;
  logic [31:0] sp_rf_wdata = '0;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // behavioural reference state
  int m_cond, m_ctrl, m_lvl;
  logic [31:0] m_live, m_ssp, m_usp;
  logic [31:0] m_plain [4];

  always #2 clk = ~clk;

  psr_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .sp_live(sp_live), .sp_rf_we(sp_rf_we), .sp_rf_wdata(sp_rf_wdata)
  );

  function automatic logic [31:0] m_read(int sel);
    int s = (m_cond >> 5) & 1;
    case (sel)
      0: return 32'(m_cond + m_ctrl * 256 + m_lvl * 65536);
      1: return 32'(m_cond);
      2: return 32'(m_ctrl);
      3: return 32'(m_lvl);
      4: return (s == 0) ? m_live : m_ssp;
      5: return (s == 1) ? m_live : m_usp;
      6, 7, 8, 9: return m_plain[sel-6];
      default: return 32'd0;
    endcase
  endfunction

  function automatic int lvl_rule(int cur, int v);
    if (cur >= 16 && v < 16) return v + 16;
    return v;
  endfunction

  task automatic m_update(int sel, bit en, bit we, logic [31:0] wd, bit rfwe, logic [31:0] rfwd);
    int s_old = (m_cond >> 5) & 1;
    bit live_taken = 0;
    logic [31:0] t;
    if (en && we) begin
      if (sel == 0 || sel == 1) begin
        int s_new = int'(wd[5]);
        if (s_new != s_old) begin
          live_taken = 1;
          if (s_old == 1) begin m_usp = m_live; m_live = m_ssp; end
          else begin t = m_live; m_live = m_usp; m_ssp = t; end
        end
        m_cond = int'(wd[5:0]);
      end
      if (sel == 0) begin
        m_ctrl = int'(wd[10:8]);
        m_lvl  = lvl_rule(m_lvl, int'(wd[20:16]));
      end
      if (sel == 2) m_ctrl = int'(wd[2:0]);
      if (sel == 3) m_lvl  = lvl_rule(m_lvl, int'(wd[4:0]));
      if (sel == 4) begin
        if (s_old == 0) begin m_live = wd; live_taken = 1; end else m_ssp = wd;
      end
      if (sel == 5) begin
        if (s_old == 1) begin m_live = wd; live_taken = 1; end else m_usp = wd;
      end
      if (sel >= 6 && sel <= 9) m_plain[sel-6] = wd;
    end
    if (rfwe && !live_taken) m_live = rfwd;
  endtask

  task automatic compare(string tag);
    logic [31:0] exp_r = m_read(int'(acc_sel));
    n_cmp += 2;
    if (acc_rdata !== exp_r) begin
      n_bad++;
      $display("FAIL %s rdata sel=%0d actual=%h expected=%h", tag, acc_sel, acc_rdata, exp_r);
    end
    if (sp_live !== m_live) begin
      n_bad++;
      $display("FAIL %s sp_live actual=%h expected=%h", tag, sp_live, m_live);
    end
  endtask

  // drive at negedge, model steps at posedge, compare at next negedge
  task automatic step(string tag, int sel, bit we, logic [31:0] wd,
                      bit rfwe = 0, logic [31:0] rfwd = 0);
    acc_en = 1'b1; acc_we = we; acc_sel = 4'(sel); acc_wdata = wd;
    sp_rf_we = rfwe; sp_rf_wdata = rfwd;
    @(posedge clk);
    m_update(sel, 1'b1, we, wd, rfwe, rfwd);
    @(negedge clk);
    acc_we = 1'b0; sp_rf_we = 1'b0;
    compare(tag);
  endtask

  task automatic rd(string tag, int sel);
    step(tag, sel, 1'b0, 32'h0);
  endtask

  initial begin
    m_cond = 0; m_ctrl = 0; m_lvl = 0;
    m_live = '0; m_ssp = '0; m_usp = '0;
    for (int i = 0; i < 4; i++) m_plain[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: everything zero after reset
    for (int s = 0; s < 16; s++) rd("R1", s);

    // R9: register-file writes to live SP
    step("R9", 12, 1'b0, 32'h0, 1'b1, 32'h0000_1111);
    // R7: system SP maps to live SP while S=0; user SP to bank
    step("R7", 4, 1'b1, 32'h0000_2222);
    step("R7", 5, 1'b1, 32'h0000_AAAA);
    rd("R7", 5);
    // R2 and R6: condition byte write flips S 0->1
    step("R2", 1, 1'b1, 32'hFFFF_FFFF);
    rd("R6", 4);
    rd("R6", 5);
    // R7: in S=1 user SP is live, system SP is bank
    step("R7", 5, 1'b1, 32'h0000_BBBB);
    step("R7", 4, 1'b1, 32'h0000_CCCC);
    // R6: same S -> no swap
    step("R6", 1, 1'b1, 32'h0000_0023);
    rd("R6", 4);
    // R6: flip 1->0
    step("R6", 1, 1'b1, 32'h0000_0001);
    rd("R6", 5);
    // R3: control field
    step("R3", 2, 1'b1, 32'hFFFF_FFFD);
    rd("R3", 0);
    // R4: level mask rule
    step("R4", 3, 1'b1, 32'h0000_0003);
    step("R4", 3, 1'b1, 32'h0000_0014);
    step("R4", 3, 1'b1, 32'h0000_0005);
    step("R4", 3, 1'b1, 32'hFFFF_FFE0);
    step("R4", 3, 1'b1, 32'h0000_001F);
    // R5: status word write with S flip and level rule
    step("R5", 0, 1'b1, 32'hFFE2_FA2C);
    rd("R5", 4);
    rd("R5", 5);
    step("R5", 0, 1'b1, 32'h001F_0115);
    rd("R5", 3);
    // R8: plain registers
    for (int i = 0; i < 4; i++) step("R8", 6 + i, 1'b1, 32'hA5A5_0000 + 32'(i * 17));
    for (int i = 0; i < 4; i++) rd("R8", 6 + i);
    // R10: reserved selects ignored
    for (int s = 10; s < 16; s++) step("R10", s, 1'b1, 32'hDEAD_BEEF);
    for (int s = 0; s < 10; s++) rd("R10", s);
    // R9: priority against access writes
    step("R9", 4, 1'b1, 32'h0000_4444, 1'b1, 32'h0000_5555);
    step("R9", 1, 1'b1, 32'h0000_0020, 1'b1, 32'h0000_6666);
    step("R9", 1, 1'b1, 32'h0000_0021, 1'b1, 32'h0000_7777);
    step("R9", 4, 1'b1, 32'h0000_8888, 1'b1, 32'h0000_9999);
    rd("R9", 4);
    rd("R9", 5);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule